// File: doc/BRIEF.md
# I2C Byte Shift Unit

This block moves one byte plus an acknowledge bit across an SDA/SCL pair for each SCL frame of nine clocks. Received bits are shifted in MSB first on rising SCL edges. They are copied into a 9-bit receive buffer at SCL edges that depend on the configured mode. At configurable SCL edges the block sets sticky interrupt request flags. Both pins pass through a synchronizer and a stability counter before any logic uses them. The filter is long in I2C mode and short otherwise.

Outgoing data is driven open-drain. A written byte is presented MSB first. Each new bit appears a fixed number of system clocks after the filtered SCL falling edge. After the ninth clock the line is released. Two configuration bits set the behaviour. The interrupt-select bit chooses between acknowledge/no-acknowledge requests and transmit/receive requests. The clock-delay bit chooses between one buffer copy and two copies. In the two-copy case the first copy uses a rotated bit packing that is undone on readback.

A four-address register port gives access to configuration, transmit data, the receive buffer and the status/pin levels. Baud generation, arbitration and start/stop generation live elsewhere. Frames are counted from the last configuration write.

Top module: `i2c_shift_unit`

## Requirements
- R1: The frame engine runs only when control bits [2:0] equal 3'b010 and control bit 3 (enable) is 1. In any other setting SCL edges set no flag and load no buffer. On every control write, the SDA drive level is forced to control bit 6 (preset level), so `sda_oe_o` equals the inverse of bit 6.
- R2: An SCL or SDA change is accepted only after it has been stable for FILT_LONG clocks while the engine runs, or FILT_SHORT clocks otherwise. Status bits [1] (SCL) and [0] (SDA) always read the filtered pin levels.
- R3: With control bit 4 (interrupt select) at 0, the 9th SCL rising edge sets flag bit 2 (ack) if SDA is low, or flag bit 3 (nack) if SDA is high.
- R4: With interrupt select at 0, the 9th SCL rising edge copies the receive buffer. Buffer bits [7:0] get the received byte, with the first bit in bit 7. Buffer bit 8 gets the SDA level of the 9th clock.
- R5: With interrupt select at 1 and control bit 5 (clock delay) at 0, the SCL falling edge that opens the 9th clock sets flag bit 5 (receive) and loads {0, byte}. The 9th rising edge sets flag bit 4 (transmit).
- R6: With interrupt select at 1 and clock delay at 1, the falling edge that opens the 9th clock sets the receive flag. The same edge stores received bits 1..7 in buffer bits 6..0 and bit 8 in buffer bit 8. While that packing is held, a read returns buffer bits 6..0 as data bits 7..1, buffer bit 8 as bit 0, and buffer bit 7 as bit 8. The 9th rising edge stores the plain {ack level, byte} and ends the remapping.
- R7: With interrupt select at 1 and clock delay at 1, the transmit flag is set on the SCL falling edge that closes the 9th clock.
- R8: A write to address 1 loads {bit 8 = ninth bit, bits [7:0] = byte} and drives byte bit 7 at once. Each later bit appears OUT_DLY clocks after the filtered SCL falling edge. The line is released after the 9th clock.
- R9: A control write clears all flags and restarts the SCL clock count.
- R10: Writing 1s to status bits [5:2] clears those flags. A flag set by an event in the same cycle stays set.
- R11: `scl_oe_o` follows control bit 7 (SCL hold).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 control, 1 transmit, 2 receive, 3 status |
| reg_wdata | input | 9 | Write data |
| reg_rdata | output | 9 | Read data for reg_addr |
| irq_o | output | 4 | Flags: 0 ack, 1 nack, 2 transmit, 3 receive |

## Verification
A software flag clear and a hardware flag set can land on the same clock edge. The bench aligns a write-one-to-clear of the ack and nack flags with the internal 9th-rising-edge event. To do this it counts the synchronizer, the filter and the edge register from the SCL pin change. Just before that frame the nack flag is set. Afterwards the ack flag must read 1 and the nack flag must read 0. A clear that won the collision, or a write one cycle late, would leave the ack flag at 0.

// File: rtl/i2c_su_pkg.sv
package i2c_su_pkg;

    typedef struct packed {
        logic       hold;
        logic       preset;
        logic       cdly;
        logic       isel;
        logic       en;
        logic [2:0] mode;
    } ctrl_t;

    localparam logic [2:0] MODE_I2C  = 3'b010;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_TX   = 2'd1;
    localparam logic [1:0] ADDR_RX   = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    localparam int FL_ACK  = 0;
    localparam int FL_NACK = 1;
    localparam int FL_TX   = 2;
    localparam int FL_RX   = 3;

    localparam ctrl_t CTRL_RESET = '{hold: 1'b0, preset: 1'b1, cdly: 1'b0,
                                     isel: 1'b0, en: 1'b0, mode: 3'b000};

endpackage

// File: rtl/i2c_su_filter.sv
module i2c_su_filter #(
    parameter int N_LONG  = 25,
    parameter int N_SHORT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic long_sel,
    output logic lvl_o
);
    localparam int CW = $clog2(N_LONG + 1);
    localparam logic [CW-1:0] LIM_L = CW'(N_LONG - 1);
    localparam logic [CW-1:0] LIM_S = CW'(N_SHORT - 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          lvl;
        logic [CW-1:0] cnt;
    } filt_t;

    filt_t st_d, st_q;
    logic [CW-1:0] lim;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_i;
        st_d.s2 = st_q.s1;
        lim     = long_sel ? LIM_L : LIM_S;
        if (st_q.s2 == st_q.lvl) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= lim) begin
            st_d.lvl = st_q.s2;
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{s1: 1'b1, s2: 1'b1, lvl: 1'b1, cnt: '0};
        else        st_q <= st_d;
    end

    assign lvl_o = st_q.lvl;

    // R2: an accepted level was already present at the synchronizer for two cycles
    a_r2_accept_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(st_q.lvl) |-> ($past(st_q.s2) == st_q.lvl) && ($past(st_q.s2, 2) == st_q.lvl));

endmodule

// File: rtl/i2c_su_txdly.sv
module i2c_su_txdly #(
    parameter int DLY = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic nxt_bit_i,
    input  logic force_i,
    input  logic force_val_i,
    output logic lvl_o
);
    localparam int DW = $clog2(DLY + 1);

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic          lvl;
    } dly_t;

    dly_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt != '0) st_d.cnt = st_q.cnt - 1'b1;
        if (st_q.cnt == DW'(1)) st_d.lvl = nxt_bit_i;
        if (start_i) st_d.cnt = DW'(DLY);
        if (force_i) begin
            st_d.lvl = force_val_i;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: '0, lvl: 1'b1};
        else        st_q <= st_d;
    end

    assign lvl_o = st_q.lvl;

    // R8: with no pending delay and no direct load, the driven level holds
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == '0 && !force_i) |=> $stable(st_q.lvl));

endmodule

// File: rtl/i2c_shift_unit.sv
module i2c_shift_unit
    import i2c_su_pkg::*;
#(
    parameter int FILT_LONG  = 25,
    parameter int FILT_SHORT = 2,
    parameter int OUT_DLY    = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_oe_o,
    output logic       sda_oe_o,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [8:0] reg_wdata,
    output logic [8:0] reg_rdata,
    output logic [3:0] irq_o
);
    localparam int NPIN = 2;

    typedef struct packed {
        ctrl_t      cfg;
        logic [3:0] flags;
        logic [3:0] bcnt;
        logic [7:0] rx_sr;
        logic [8:0] rbuf;
        logic       rot;
        logic [8:0] tx_sr;
        logic       scl_p;
    } core_t;

    core_t st_d, st_q;

    logic [NPIN-1:0] pin_raw, pin_f;
    logic scl_f, sda_f, active, rise, fall;
    logic tx_start, tx_force, tx_force_val, tx_lvl;
    logic [3:0] setf;

    assign active  = (st_q.cfg.mode == MODE_I2C) && st_q.cfg.en;
    assign pin_raw = {scl_i, sda_i};

    for (genvar g = 0; g < NPIN; g++) begin : g_filt
        i2c_su_filter #(.N_LONG(FILT_LONG), .N_SHORT(FILT_SHORT)) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_i    (pin_raw[g]),
            .long_sel (active),
            .lvl_o    (pin_f[g])
        );
    end

    assign sda_f = pin_f[0];
    assign scl_f = pin_f[1];
    assign rise  = scl_f & ~st_q.scl_p;
    assign fall  = ~scl_f & st_q.scl_p;

    always_comb begin
        st_d         = st_q;
        st_d.scl_p   = scl_f;
        setf         = '0;
        tx_start     = 1'b0;
        tx_force     = 1'b0;
        tx_force_val = 1'b1;

        if (active && rise) begin
            if (st_q.bcnt < 4'd8) begin
                st_d.rx_sr = {st_q.rx_sr[6:0], sda_f};
                st_d.bcnt  = st_q.bcnt + 4'd1;
            end else if (st_q.bcnt == 4'd8) begin
                st_d.bcnt = 4'd9;
                if (!st_q.cfg.isel) begin
                    st_d.rbuf = {sda_f, st_q.rx_sr};
                    st_d.rot  = 1'b0;
                    if (sda_f) setf[FL_NACK] = 1'b1;
                    else       setf[FL_ACK]  = 1'b1;
                end else if (!st_q.cfg.cdly) begin
                    setf[FL_TX] = 1'b1;
                end else begin
                    st_d.rbuf = {sda_f, st_q.rx_sr};
                    st_d.rot  = 1'b0;
                end
            end
        end

        if (active && fall && st_q.bcnt != 4'd0) begin
            st_d.tx_sr = {st_q.tx_sr[7:0], 1'b1};
            tx_start   = 1'b1;
            if (st_q.bcnt == 4'd8 && st_q.cfg.isel) begin
                setf[FL_RX] = 1'b1;
                if (st_q.cfg.cdly) begin
                    st_d.rbuf = {st_q.rx_sr[0], 1'b0, st_q.rx_sr[7:1]};
                    st_d.rot  = 1'b1;
                end else begin
                    st_d.rbuf = {1'b0, st_q.rx_sr};
                    st_d.rot  = 1'b0;
                end
            end
            if (st_q.bcnt == 4'd9) begin
                st_d.bcnt = 4'd0;
                if (st_q.cfg.isel && st_q.cfg.cdly) setf[FL_TX] = 1'b1;
            end
        end

        st_d.flags = st_q.flags | setf;
        if (reg_we && reg_addr == ADDR_STAT)
            st_d.flags = (st_q.flags & ~reg_wdata[5:2]) | setf;

        if (reg_we && reg_addr == ADDR_TX) begin
            st_d.tx_sr   = {reg_wdata[7:0], reg_wdata[8]};
            tx_force     = 1'b1;
            tx_force_val = reg_wdata[7];
        end

        if (reg_we && reg_addr == ADDR_CTRL) begin
            st_d.cfg     = ctrl_t'(reg_wdata[7:0]);
            st_d.flags   = '0;
            st_d.bcnt    = '0;
            st_d.tx_sr   = '1;
            tx_force     = 1'b1;
            tx_force_val = reg_wdata[6];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.cfg   <= CTRL_RESET;
            st_q.tx_sr <= '1;
            st_q.scl_p <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    i2c_su_txdly #(.DLY(OUT_DLY)) u_txdly (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (tx_start),
        .nxt_bit_i   (st_q.tx_sr[8]),
        .force_i     (tx_force),
        .force_val_i (tx_force_val),
        .lvl_o       (tx_lvl)
    );

    always_comb begin
        case (reg_addr)
            ADDR_CTRL: reg_rdata = {1'b0, st_q.cfg};
            ADDR_RX:   reg_rdata = st_q.rot ? {st_q.rbuf[7], st_q.rbuf[6:0], st_q.rbuf[8]}
                                            : st_q.rbuf;
            ADDR_STAT: reg_rdata = {3'b000, st_q.flags, scl_f, sda_f};
            default:   reg_rdata = '0;
        endcase
    end

    assign sda_oe_o = ~tx_lvl;
    assign scl_oe_o = st_q.cfg.hold;
    assign irq_o    = st_q.flags;

    // R1: an inactive engine never raises a new flag
    a_r1_idle_no_new_flags: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> ((st_q.flags & ~$past(st_q.flags)) == 4'b0000));

    // R3: ack/nack requests only come from the interrupt-select = 0 setting
    a_r3_acknack_source: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.flags[FL_ACK]) || $rose(st_q.flags[FL_NACK])) |-> !$past(st_q.cfg.isel));

    // R7: in clock-delay mode the transmit request coincides with the end of the frame
    a_r7_tx_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(st_q.flags[FL_TX]) && $past(st_q.cfg.cdly)) |-> (st_q.bcnt == 4'd0));

    // R9: a control write leaves no pending request
    a_r9_cfg_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_CTRL) |=> (st_q.flags == 4'b0000));

endmodule

// File: tb/i2c_shift_unit_test.sv
module i2c_shift_unit_test;

    localparam int FN = 25;
    localparam int DL = 6;
    localparam int H  = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_drv = 1'b1;
    logic       sda_drv = 1'b1;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [8:0] reg_wdata = '0;
    logic [8:0] reg_rdata;
    logic [3:0] irq_o;
    logic       scl_oe_o, sda_oe_o;
    logic       scl_i, sda_i;

    assign scl_i = scl_drv & ~scl_oe_o;
    assign sda_i = sda_drv & ~sda_oe_o;

    always #4 clk = ~clk;

    i2c_shift_unit #(.FILT_LONG(FN), .FILT_SHORT(2), .OUT_DLY(DL)) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    typedef struct {
        logic [1:0] addr;
        logic [8:0] mask;
        logic [8:0] exp;
        string      tag;
    } item_t;

    item_t q[$];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [8:0] FMASK = 9'h03C;

    initial begin : monitor
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_chk++;
                if ((reg_rdata & it.mask) !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s addr=%0d actual=%h expected=%h", it.tag, it.addr,
                             reg_rdata & it.mask, it.exp);
                end
            end
        end
    end

    task automatic expect_reg(input logic [1:0] a, input logic [8:0] m,
                              input logic [8:0] e, input string tag);
        item_t it;
        @(negedge clk);
        reg_addr = a;
        it.addr = a; it.mask = m; it.exp = e & m; it.tag = tag;
        q.push_back(it);
        wait (q.size() == 0);
    endtask

    task automatic check_pin(input logic act, input logic e, input string tag);
        n_chk++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, e);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [8:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_cycle(input logic b, input int idx, input bit chk, input logic [7:0] txb);
        sda_drv = b;
        wait_n(H);
        scl_drv = 1'b1;
        wait_n(H);
        if (chk) check_pin(sda_oe_o, ~txb[7-idx], "R8 bit level");
        scl_drv = 1'b0;
        if (chk && idx == 0) begin
            wait_n(FN + DL + 2);
            check_pin(sda_oe_o, ~txb[7], "R8 before output delay");
            wait_n(1);
            check_pin(sda_oe_o, ~txb[6], "R8 after output delay");
            wait_n(H - FN - DL - 3);
        end else begin
            wait_n(H);
        end
    endtask

    task automatic data8(input logic [7:0] byt, input bit chk, input logic [7:0] txb);
        for (int i = 0; i < 8; i++) bit_cycle(byt[7-i], i, chk, txb);
    endtask

    task automatic nine_rise(input logic ackb);
        sda_drv = ackb;
        wait_n(H);
        scl_drv = 1'b1;
        wait_n(H);
    endtask

    task automatic nine_fall();
        scl_drv = 1'b0;
        wait_n(H);
        sda_drv = 1'b1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : driver
        wait_n(5);
        rst_n = 1'b1;
        wait_n(2);

        // reset state
        expect_reg(2'd0, 9'h1FF, 9'h040, "R1 reset control");
        expect_reg(2'd2, 9'h1FF, 9'h000, "R4 reset buffer");
        check_pin(sda_oe_o, 1'b0, "R1 reset sda released");
        check_pin(scl_oe_o, 1'b0, "R11 reset scl released");
        n_chk++;
        if (irq_o !== 4'h0) begin n_bad++; $display("FAIL R9 reset irq actual=%h expected=0", irq_o); end

        // R1: disabled engine ignores a full frame
        scl_drv = 1'b0; wait_n(H);
        data8(8'h55, 1'b0, 8'h00);
        nine_rise(1'b0);
        nine_fall();
        expect_reg(2'd3, FMASK, 9'h000, "R1 no flags when disabled");
        expect_reg(2'd2, 9'h1FF, 9'h000, "R1 no buffer load when disabled");
        wr(2'd0, 9'h000);
        check_pin(sda_oe_o, 1'b1, "R1 preset level 0 drives SDA");
        wr(2'd0, 9'h040);
        check_pin(sda_oe_o, 1'b0, "R1 preset level 1 releases SDA");

        // R2: filter widths and pin readback
        scl_drv = 1'b1; wait_n(H);
        wr(2'd0, 9'h04A);
        expect_reg(2'd3, 9'h003, 9'h003, "R2 pins read high");
        scl_drv = 1'b0; wait_n(H);
        expect_reg(2'd3, 9'h002, 9'h000, "R2 scl reads low");
        scl_drv = 1'b1; wait_n(8);
        expect_reg(2'd3, 9'h002, 9'h000, "R2 long filter blocks glitch");
        scl_drv = 1'b0; wait_n(H);
        wr(2'd0, 9'h040);
        scl_drv = 1'b1; wait_n(6);
        expect_reg(2'd3, 9'h002, 9'h002, "R2 short filter passes pulse");
        scl_drv = 1'b0; wait_n(H);

        // R3/R4: interrupt select 0, ack
        wr(2'd0, 9'h04A);
        data8(8'hA5, 1'b0, 8'h00);
        expect_reg(2'd3, FMASK, 9'h000, "R3 no flag before ninth rise");
        nine_rise(1'b0);
        expect_reg(2'd3, FMASK, 9'h004, "R3 ack flag");
        expect_reg(2'd2, 9'h1FF, 9'h0A5, "R4 copy at ninth rise");
        nine_fall();
        wr(2'd3, 9'h004);
        expect_reg(2'd3, FMASK, 9'h000, "R10 write-one clears ack");

        // R3/R4: nack
        data8(8'h3C, 1'b0, 8'h00);
        nine_rise(1'b1);
        expect_reg(2'd3, FMASK, 9'h008, "R3 nack flag");
        expect_reg(2'd2, 9'h1FF, 9'h13C, "R4 ninth level in bit 8");
        nine_fall();

        // R10: clear and set in the same cycle
        data8(8'h5A, 1'b0, 8'h00);
        expect_reg(2'd3, FMASK, 9'h008, "R10 nack still pending");
        sda_drv = 1'b0;
        wait_n(H);
        scl_drv = 1'b1;
        wait_n(FN + 2);
        reg_we = 1'b1; reg_addr = 2'd3; reg_wdata = 9'h00C;
        @(negedge clk);
        reg_we = 1'b0;
        wait_n(H - FN - 3);
        expect_reg(2'd3, FMASK, 9'h004, "R10 set wins over clear");
        expect_reg(2'd2, 9'h1FF, 9'h05A, "R4 collision frame buffer");
        nine_fall();

        // R5: interrupt select 1, no clock delay
        wr(2'd0, 9'h05A);
        expect_reg(2'd3, FMASK, 9'h000, "R9 control write clears flags");
        data8(8'hC3, 1'b0, 8'h00);
        expect_reg(2'd3, FMASK, 9'h020, "R5 receive flag at opening fall");
        expect_reg(2'd2, 9'h1FF, 9'h0C3, "R5 copy at opening fall");
        nine_rise(1'b0);
        expect_reg(2'd3, FMASK, 9'h030, "R5 transmit flag at ninth rise");
        nine_fall();

        // R6/R7: interrupt select 1, clock delay
        wr(2'd0, 9'h07A);
        expect_reg(2'd3, FMASK, 9'h000, "R9 flags cleared again");
        data8(8'h96, 1'b0, 8'h00);
        expect_reg(2'd3, FMASK, 9'h020, "R6 receive flag at opening fall");
        expect_reg(2'd2, 9'h1FF, 9'h096, "R6 rotated readback");
        nine_rise(1'b1);
        expect_reg(2'd2, 9'h1FF, 9'h196, "R6 second plain copy");
        expect_reg(2'd3, FMASK, 9'h020, "R7 no transmit flag at ninth rise");
        nine_fall();
        expect_reg(2'd3, FMASK, 9'h030, "R7 transmit flag at closing fall");

        // R8: transmit path with delayed output
        wr(2'd0, 9'h04A);
        wr(2'd1, 9'h16B);
        check_pin(sda_oe_o, 1'b1, "R8 first bit driven on write");
        data8(8'hFF, 1'b1, 8'h6B);
        nine_rise(1'b0);
        check_pin(sda_oe_o, 1'b0, "R8 ninth bit released");
        expect_reg(2'd2, 9'h1FF, 9'h06B, "R8 looped byte received");
        nine_fall();
        check_pin(sda_oe_o, 1'b0, "R8 released after frame");

        // R11: SCL hold
        wr(2'd0, 9'h0CA);
        check_pin(scl_oe_o, 1'b1, "R11 hold drives SCL");
        wr(2'd0, 9'h04A);
        check_pin(scl_oe_o, 1'b0, "R11 hold off releases SCL");

        wait_n(4);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule